// File: doc/BRIEF.md
# Split Accumulator with Low-Half Preservation

This block is a 32-bit working register built from two 16-bit halves, a high half and a low half, with a small arithmetic and logic unit beside it. A command interface carries an operation, an operand size (byte, word or long), a sign-extension choice, a 32-bit operand and a valid strobe. One command is taken on every clock. Long commands use both halves as a single 32-bit value. Word and byte commands use only the low half.

A narrow load (word or byte) writes the low half and moves the previous low half into the high half in the same clock, so a sequence of narrow loads keeps the last two values in hand. Byte loads are widened to 16 bits by sign or zero extension. Byte arithmetic ignores the upper byte of the low half and clears it in the result. A source-select input replaces the external operand with the high half, so the two halves can be combined with each other. The halves have no reset value. Only the zero and carry flags are cleared by reset.

Top module: `split_accum`

## Requirements
- R1: A long load (op 0, size 2'b10) writes cmd_data[31:16] to the high half and cmd_data[15:0] to the low half. No preservation move takes place.
- R2: A word load (op 0, size 2'b01) writes cmd_data[15:0] to the low half and copies the previous low half into the high half in the same clock.
- R3: A byte load (op 0, size 2'b00) writes cmd_data[7:0] to bits 7:0 of the low half. Bits 15:8 take bit 7 when cmd_sext is 1 and zero when cmd_sext is 0. The previous low half moves into the high half.
- R4: Long arithmetic (op 1 add, 2 sub, 3 and, 4 or, 5 xor, size 2'b10) combines the full 32-bit value with cmd_data and writes the result to both halves.
- R5: Word arithmetic (size 2'b01) combines the low half with cmd_data[15:0] and writes only the low half. The high half is unchanged.
- R6: Byte arithmetic (size 2'b00) uses only bits 7:0 of the low half and of the operand. It writes the 8-bit result to bits 7:0 and zero to bits 15:8 of the low half. The high half is unchanged.
- R7: When cmd_use_high is 1, an arithmetic command uses the high half as its operand in place of cmd_data. The result goes to the low half only, and the high half is unchanged. Size 2'b10 is treated as word in this case.
- R8: After an arithmetic command, flag_zero is 1 when the result is zero at the operation width. flag_carry holds the carry out for add, the borrow for sub, and 0 for logic ops. Loads leave both flags unchanged.
- R9: A synchronous active-high reset clears flag_zero and flag_carry to 0. The two halves are not initialized.
- R10: A command is ignored, and the value and flags stay as they were, when cmd_valid is 0, when cmd_size is 2'b11, or when cmd_op is 6 or 7.
- R11: A command's effect appears on acc_value and the flags after the clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (flags only) |
| cmd_valid | input | 1 | Command strobe, one command per clock |
| cmd_op | input | 3 | 0 load, 1 add, 2 sub, 3 and, 4 or, 5 xor |
| cmd_size | input | 2 | 00 byte, 01 word, 10 long |
| cmd_sext | input | 1 | Byte load: 1 sign-extends, 0 zero-extends |
| cmd_use_high | input | 1 | Arithmetic: high half replaces the operand |
| cmd_data | input | 32 | Operand value |
| acc_value | output | 32 | High half in bits 31:16, low half in bits 15:0 |
| flag_zero | output | 1 | Result was zero at operation width |
| flag_carry | output | 1 | Carry (add) or borrow (sub) at operation width |

## Verification
On a byte load, the preservation move and the extension of the new byte act in the same clock. They write different halves from different sources.

The bench provokes this in two ways:
- It loads a low half whose upper byte differs from the extension fill, then byte-loads a value with bit 7 set, once with sign extension and once without. Both halves must then show the old low half above and the correctly filled byte below.
- It issues narrow loads on consecutive clocks, so that each move takes the value the previous load just wrote. This is judged by the pair of values left in the halves.

// File: rtl/split_accum_pkg.sv
package split_accum_pkg;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5
  } acc_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } acc_size_e;

  localparam int NUM_LANES = 3;

endpackage

// File: rtl/sa_loadfmt.sv
module sa_loadfmt
  import split_accum_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic [1:0]        size,
  input  logic              sext,
  input  logic [FULL_W-1:0] data,
  input  logic [HALF_W-1:0] old_lo,
  output logic [HALF_W-1:0] hi_d,
  output logic [HALF_W-1:0] lo_d
);

  logic fill;

  assign fill = sext & data[BYTE_W-1];

  always_comb begin
    hi_d = old_lo;
    lo_d = data[HALF_W-1:0];
    case (size)
      SZ_BYTE: lo_d = {{BYTE_W{fill}}, data[BYTE_W-1:0]};
      SZ_WORD: lo_d = data[HALF_W-1:0];
      SZ_LONG: begin
        hi_d = data[FULL_W-1:HALF_W];
        lo_d = data[HALF_W-1:0];
      end
      default: lo_d = data[HALF_W-1:0];
    endcase
  end

endmodule

// File: rtl/sa_alu.sv
module sa_alu
  import split_accum_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic [2:0]        op,
  input  logic [1:0]        lane_sel,
  input  logic [FULL_W-1:0] a,
  input  logic [FULL_W-1:0] b,
  output logic [FULL_W-1:0] res,
  output logic              zero,
  output logic              carry
);

  logic [FULL_W-1:0] lane_res [NUM_LANES];
  logic [NUM_LANES-1:0] lane_z;
  logic [NUM_LANES-1:0] lane_c;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int GW = BYTE_W << g;
    logic [GW:0]   sum;
    logic [GW:0]   dif;
    logic [GW-1:0] r;
    logic          c;

    always_comb begin
      sum = {1'b0, a[GW-1:0]} + {1'b0, b[GW-1:0]};
      dif = {1'b0, a[GW-1:0]} - {1'b0, b[GW-1:0]};
      r   = '0;
      c   = 1'b0;
      case (op)
        OP_ADD: begin r = sum[GW-1:0]; c = sum[GW]; end
        OP_SUB: begin r = dif[GW-1:0]; c = dif[GW]; end
        OP_AND: r = a[GW-1:0] & b[GW-1:0];
        OP_OR:  r = a[GW-1:0] | b[GW-1:0];
        OP_XOR: r = a[GW-1:0] ^ b[GW-1:0];
        default: r = '0;
      endcase
    end

    assign lane_res[g] = FULL_W'(r);
    assign lane_z[g]   = (r == '0);
    assign lane_c[g]   = c;
  end

  always_comb begin
    case (lane_sel)
      SZ_WORD: begin res = lane_res[1]; zero = lane_z[1]; carry = lane_c[1]; end
      SZ_LONG: begin res = lane_res[2]; zero = lane_z[2]; carry = lane_c[2]; end
      default: begin res = lane_res[0]; zero = lane_z[0]; carry = lane_c[0]; end
    endcase
  end

endmodule

// File: rtl/sa_halves.sv
module sa_halves #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [HALF_W-1:0] hi_d,
  input  logic [HALF_W-1:0] lo_d,
  input  logic              flag_we,
  input  logic              z_d,
  input  logic              c_d,
  output logic [HALF_W-1:0] hi_q,
  output logic [HALF_W-1:0] lo_q,
  output logic              z_q,
  output logic              c_q
);

  // Data halves carry no reset: their value is undefined until first written.
  always_ff @(posedge clk) begin
    if (we_hi) hi_q <= hi_d;
    if (we_lo) lo_q <= lo_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (flag_we) begin
      z_q <= z_d;
      c_q <= c_d;
    end
  end

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(z_q) && $stable(c_q));

  p_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we_hi |=> hi_q == $past(hi_q));

endmodule

// File: rtl/split_accum.sv
module split_accum
  import split_accum_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_sext,
  input  logic              cmd_use_high,
  input  logic [FULL_W-1:0] cmd_data,
  output logic [FULL_W-1:0] acc_value,
  output logic              flag_zero,
  output logic              flag_carry
);

  logic              size_ok, accept, do_load, do_arith;
  logic [1:0]        lane_sel;
  logic [HALF_W-1:0] hi_q, lo_q, ld_hi, ld_lo, hi_d, lo_d;
  logic [FULL_W-1:0] alu_b, alu_res;
  logic              alu_z, alu_c, we_hi, we_lo;

  assign size_ok  = (cmd_size != 2'b11);
  assign accept   = cmd_valid && size_ok;
  assign do_load  = accept && (cmd_op == OP_LOAD);
  assign do_arith = accept && (cmd_op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR});

  // High-half source narrows a long request down to word width.
  assign lane_sel = (cmd_use_high && cmd_size == SZ_LONG) ? SZ_WORD : cmd_size;
  assign alu_b    = cmd_use_high ? FULL_W'(hi_q) : cmd_data;

  sa_loadfmt #(.BYTE_W(BYTE_W)) u_fmt (
    .size   (cmd_size),
    .sext   (cmd_sext),
    .data   (cmd_data),
    .old_lo (lo_q),
    .hi_d   (ld_hi),
    .lo_d   (ld_lo)
  );

  sa_alu #(.BYTE_W(BYTE_W)) u_alu (
    .op       (cmd_op),
    .lane_sel (lane_sel),
    .a        ({hi_q, lo_q}),
    .b        (alu_b),
    .res      (alu_res),
    .zero     (alu_z),
    .carry    (alu_c)
  );

  assign we_lo = do_load || do_arith;
  assign we_hi = do_load || (do_arith && lane_sel == SZ_LONG);
  assign hi_d  = do_load ? ld_hi : alu_res[FULL_W-1:HALF_W];
  assign lo_d  = do_load ? ld_lo : alu_res[HALF_W-1:0];

  sa_halves #(.HALF_W(HALF_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_hi   (we_hi),
    .we_lo   (we_lo),
    .hi_d    (hi_d),
    .lo_d    (lo_d),
    .flag_we (do_arith),
    .z_d     (alu_z),
    .c_d     (alu_c),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .z_q     (flag_zero),
    .c_q     (flag_carry)
  );

  assign acc_value = {hi_q, lo_q};

  p_long_load_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LOAD && cmd_size == SZ_LONG
    |=> acc_value == $past(cmd_data));

  p_word_push_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LOAD && cmd_size == SZ_WORD
    |=> acc_value[FULL_W-1:HALF_W] == $past(acc_value[HALF_W-1:0])
        && acc_value[HALF_W-1:0] == $past(cmd_data[HALF_W-1:0]));

  p_byte_push_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LOAD && cmd_size == SZ_BYTE
    |=> acc_value[FULL_W-1:HALF_W] == $past(acc_value[HALF_W-1:0])
        && acc_value[BYTE_W-1:0] == $past(cmd_data[BYTE_W-1:0]));

  p_byte_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    do_arith && cmd_size == SZ_BYTE
    |=> acc_value[HALF_W-1:BYTE_W] == '0
        && acc_value[FULL_W-1:HALF_W] == $past(acc_value[FULL_W-1:HALF_W]));

  p_high_src_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    do_arith && cmd_use_high
    |=> acc_value[FULL_W-1:HALF_W] == $past(acc_value[FULL_W-1:HALF_W]));

  p_load_flags_r8: assert property (@(posedge clk) disable iff (rst)
    do_load |=> $stable(flag_zero) && $stable(flag_carry));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(acc_value) && $stable(flag_zero) && $stable(flag_carry));

endmodule

// File: tb/split_accum_tb.sv
module split_accum_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_size = '0;
  logic        cmd_sext = 1'b0;
  logic        cmd_use_high = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [31:0] acc_value;
  logic        flag_zero, flag_carry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  split_accum u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_size(cmd_size), .cmd_sext(cmd_sext), .cmd_use_high(cmd_use_high),
    .cmd_data(cmd_data), .acc_value(acc_value), .flag_zero(flag_zero),
    .flag_carry(flag_carry)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic sx,
                       input logic hi, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_size = sz; cmd_sext = sx;
    cmd_use_high = hi; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 zero after reset", {31'b0, flag_zero}, 32'd0);
    check("R9 carry after reset", {31'b0, flag_carry}, 32'd0);
  endtask

  task automatic t_latency();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h1357_9BDF);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_size = 2'b10; cmd_data = 32'h8F74_2B52;
    #1 check("R11 no change before edge", acc_value, 32'h1357_9BDF);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 long load", acc_value, 32'h8F74_2B52);
  endtask

  task automatic t_narrow_loads();
    issue(3'd0, 2'b01, 1'b0, 1'b0, 32'hFFFF_1234);
    check("R2 word load push", acc_value, 32'h2B52_1234);
    issue(3'd0, 2'b00, 1'b1, 1'b0, 32'h0000_00A6);
    check("R3 byte sign-extend push", acc_value, 32'h1234_FFA6);
    issue(3'd0, 2'b00, 1'b0, 1'b0, 32'hFFFF_FFA6);
    check("R3 byte zero-extend push", acc_value, 32'hFFA6_00A6);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_size = 2'b01; cmd_sext = 1'b0;
    cmd_use_high = 1'b0; cmd_data = 32'h0000_1111;
    @(negedge clk);
    cmd_data = 32'h0000_2222;
    @(negedge clk);
    cmd_size = 2'b00; cmd_sext = 1'b1; cmd_data = 32'h0000_0080;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 R3 back-to-back push chain", acc_value, 32'h2222_FF80);
  endtask

  task automatic t_long_arith();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF);
    issue(3'd1, 2'b10, 1'b0, 1'b0, 32'h0000_0001);
    check("R4 long add wrap", acc_value, 32'h0000_0000);
    check("R8 long add zero", {31'b0, flag_zero}, 32'd1);
    check("R8 long add carry", {31'b0, flag_carry}, 32'd1);
    issue(3'd2, 2'b10, 1'b0, 1'b0, 32'h0000_0001);
    check("R4 long sub borrow", acc_value, 32'hFFFF_FFFF);
    check("R8 long sub borrow flag", {30'b0, flag_zero, flag_carry}, 32'd1);
    issue(3'd5, 2'b10, 1'b0, 1'b0, 32'h0F0F_F0F0);
    check("R4 long xor", acc_value, 32'hF0F0_0F0F);
    check("R8 logic clears carry", {31'b0, flag_carry}, 32'd0);
  endtask

  task automatic t_word_arith();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'hABCD_FFF0);
    issue(3'd1, 2'b01, 1'b0, 1'b0, 32'h5555_0010);
    check("R5 word add keeps high", acc_value, 32'hABCD_0000);
    check("R8 word flags", {30'b0, flag_zero, flag_carry}, 32'd3);
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h0000_0001);
    issue(3'd2, 2'b01, 1'b0, 1'b0, 32'h0000_0002);
    check("R5 word sub", acc_value, 32'h0000_FFFF);
    check("R8 word borrow", {30'b0, flag_zero, flag_carry}, 32'd1);
  endtask

  task automatic t_byte_arith();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h1111_77F0);
    issue(3'd1, 2'b00, 1'b0, 1'b0, 32'hFFFF_FF20);
    check("R6 byte add clears upper", acc_value, 32'h1111_0010);
    check("R8 byte carry", {30'b0, flag_zero, flag_carry}, 32'd1);
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h2222_C3A5);
    issue(3'd3, 2'b00, 1'b0, 1'b0, 32'h0000_000F);
    check("R6 byte and", acc_value, 32'h2222_0005);
  endtask

  task automatic t_high_source();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h0003_0005);
    issue(3'd2, 2'b01, 1'b0, 1'b1, 32'hDEAD_BEEF);
    check("R7 low minus high", acc_value, 32'h0003_0002);
    issue(3'd1, 2'b10, 1'b0, 1'b1, 32'hDEAD_BEEF);
    check("R7 long size as word", acc_value, 32'h0003_0005);
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h12FF_34F0);
    issue(3'd5, 2'b00, 1'b0, 1'b1, 32'h0000_0000);
    check("R7 byte xor with high", acc_value, 32'h12FF_000F);
  endtask

  task automatic t_load_flags();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'h0000_0000);
    issue(3'd1, 2'b10, 1'b0, 1'b0, 32'h0000_0000);
    issue(3'd0, 2'b01, 1'b0, 1'b0, 32'h0000_0001);
    check("R8 load keeps zero flag", {31'b0, flag_zero}, 32'd1);
  endtask

  task automatic t_ignored();
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF);
    issue(3'd1, 2'b10, 1'b0, 1'b0, 32'h0000_0001);
    issue(3'd0, 2'b10, 1'b0, 1'b0, 32'hCAFE_F00D);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd1; cmd_size = 2'b10; cmd_data = 32'h1;
    @(negedge clk);
    check("R10 valid low ignored", acc_value, 32'hCAFE_F00D);
    issue(3'd0, 2'b11, 1'b0, 1'b0, 32'h0000_0000);
    check("R10 size 11 ignored", acc_value, 32'hCAFE_F00D);
    issue(3'd2, 2'b11, 1'b0, 1'b0, 32'h0000_0001);
    check("R10 size 11 arith flags kept", {30'b0, flag_zero, flag_carry}, 32'd3);
    issue(3'd6, 2'b10, 1'b0, 1'b0, 32'h0000_0000);
    check("R10 op 6 ignored", acc_value, 32'hCAFE_F00D);
    issue(3'd7, 2'b01, 1'b0, 1'b0, 32'h0000_0001);
    check("R10 op 7 ignored", acc_value, 32'hCAFE_F00D);
    check("R10 op 7 flags kept", {30'b0, flag_zero, flag_carry}, 32'd3);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_narrow_loads();
    t_back_to_back();
    t_long_arith();
    t_word_arith();
    t_byte_arith();
    t_high_source();
    t_load_flags();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule